// File: doc/BRIEF.md
# Mixed Live and Sticky Fault Status Register

This block holds one byte of fault and condition status for a power-management command interface. Each of the eight bit positions has its own input from monitoring logic. Six positions are sticky: a high input sets the bit and it stays set after the input falls. The other two (the conduction-mode flag in bit 7 and the power-stage over-temperature flag in bit 1) are live and always show their input as it is now. Inputs are assumed to be synchronous to `clk` already.

The host reaches the register through a simple command port. A read of command code 0x80 captures a snapshot of the byte, which is returned one cycle later with `rd_valid`. A write to 0x80 clears every sticky bit whose position holds a 1 in the write data. The `clear_all` strobe clears every sticky bit at once. Set always wins over clear: a bit whose input is high in the cycle it is cleared stays at 1. Updates take effect at once, and nothing is kept through a power cycle.

A two-state decode machine drives the read response. `ST_IDLE` is the rest state. The transition "read hit" (a read of 0x80) moves it to `ST_RESPOND`, where `rd_valid` is high for one cycle. From `ST_RESPOND`, a further read hit keeps it there and any other cycle takes it back to `ST_IDLE`. Writes and clears act on the flag storage directly and do not change the state.

Top module: `status_mixed_reg`

## Requirements
- R1: After reset every sticky bit is 0, `rd_valid` is 0, and a read with all inputs low returns 0x00.
- R2: Sticky bits 6, 5, 4, 3, 2 and 0 set when their input is high at a clock edge and stay 1 after the input falls.
- R3: Bit 7 (1 = discontinuous-conduction mode, 0 = continuous) and bit 1 (power-stage over-temperature) are not stored; a read returns the value their inputs had in the cycle the read was accepted.
- R4: A write to code 0x80 clears each sticky bit whose position is 1 in `cmd_wdata`; positions written 0 keep their value.
- R5: Write-data ones in positions 7 and 1 have no effect: those bits still follow their inputs afterwards.
- R6: A one-cycle `clear_all` pulse clears every sticky bit.
- R7: If a sticky bit's input is high in the cycle it is cleared (by write or by `clear_all`), the bit stays 1 and reads back as 1.
- R8: A command with any code other than 0x80 changes no bit and produces no read response.
- R9: A read accepted at one clock edge raises `rd_valid` for exactly the next cycle; `rd_data` then holds the live bits' inputs and each sticky bit ORed with its input, both as they were in the accept cycle.
- R10: Reads on consecutive cycles each produce their own response on consecutive cycles, each reflecting the inputs of its own accept cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_in | input | 8 | Condition inputs, one per bit position |
| clear_all | input | 1 | Global clear strobe for sticky bits |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_code | input | 8 | Command code of the transaction |
| cmd_wdata | input | 8 | Write data: ones select sticky bits to clear |
| rd_data | output | 8 | Read snapshot, valid while `rd_valid` is high |
| rd_valid | output | 1 | Read response strobe, one cycle per accepted read |

## Verification
Single-cycle input pulses followed by reads tell sticky positions from live ones, since only sticky bits still show 1 after the pulse is gone. Writes with single-bit and mixed masks, including ones at the live positions, show that clearing is per bit and that live positions ignore it. Clears issued while an input is held high separate set-over-clear priority from plain clearing, and commands at neighbouring codes show that the decode is exact. A long run of pseudo-random inputs, commands and clears, with reads back to back, is then compared every cycle against a behavioural model.

// File: rtl/smr_pkg.sv
package smr_pkg;

    // Decode machine states
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_RESPOND = 1'b1
    } smr_state_e;

    // Default geometry of the status byte
    localparam int unsigned SMR_DATA_W     = 8;
    localparam int unsigned SMR_CMD_W      = 8;
    localparam logic [7:0]  SMR_CODE_DEF   = 8'h80;
    // Positions 6,5,4,3,2,0 are sticky; 7 and 1 are live
    localparam logic [7:0]  SMR_STICKY_DEF = 8'b0111_1101;

endpackage

// File: rtl/smr_cmd_decode.sv
module smr_cmd_decode
    import smr_pkg::*;
#(
    parameter int unsigned CMD_W    = SMR_CMD_W,
    parameter int unsigned DATA_W   = SMR_DATA_W,
    parameter logic [CMD_W-1:0] CODE = CMD_W'(SMR_CODE_DEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              clear_all,
    output logic              rd_hit,
    output logic [DATA_W-1:0] clr_mask,
    output logic              rd_valid
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    smr_state_e state_q, state_d;
    logic       code_match;
    logic       wr_hit;

    always_comb begin
        code_match = cmd_valid && (cmd_code == CODE);
        rd_hit     = code_match && !cmd_write;
        wr_hit     = code_match &&  cmd_write;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = rd_hit ? ST_RESPOND : ST_IDLE;
            ST_RESPOND: state_d = rd_hit ? ST_RESPOND : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        rd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:    rd_valid = 1'b0;
            ST_RESPOND: rd_valid = 1'b1;
            default:    rd_valid = 1'b0;
        endcase
        clr_mask = (wr_hit ? cmd_wdata : '0) | (clear_all ? ALL_ONES : '0);
    end

endmodule

// File: rtl/smr_flag_bank.sv
module smr_flag_bank
    import smr_pkg::*;
#(
    parameter int unsigned DATA_W        = SMR_DATA_W,
    parameter logic [DATA_W-1:0] STICKY  = DATA_W'(SMR_STICKY_DEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] fault_in,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] stored_q,
    output logic [DATA_W-1:0] view
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (STICKY[i]) begin : g_sticky
            logic bit_q;
            // Set wins over clear
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= (bit_q & ~clr_mask[i]) | fault_in[i];
            end
            assign stored_q[i] = bit_q;
            assign view[i]     = bit_q | fault_in[i];
        end else begin : g_live
            assign stored_q[i] = 1'b0;
            assign view[i]     = fault_in[i];
        end
    end

endmodule

// File: rtl/smr_read_mux.sv
module smr_read_mux
    import smr_pkg::*;
#(
    parameter int unsigned DATA_W = SMR_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] view,
    output logic [DATA_W-1:0] snap_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (capture) snap_q <= view;
    end

endmodule

// File: rtl/status_mixed_reg.sv
module status_mixed_reg
    import smr_pkg::*;
#(
    parameter int unsigned CMD_W        = SMR_CMD_W,
    parameter int unsigned DATA_W       = SMR_DATA_W,
    parameter logic [CMD_W-1:0] CODE    = CMD_W'(SMR_CODE_DEF),
    parameter logic [DATA_W-1:0] STICKY = DATA_W'(SMR_STICKY_DEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] fault_in,
    input  logic              clear_all,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic              rd_hit;
    logic [DATA_W-1:0] clr_mask;
    logic [DATA_W-1:0] stored_q;
    logic [DATA_W-1:0] view;

    smr_cmd_decode #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CODE(CODE)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_code  (cmd_code),
        .cmd_wdata (cmd_wdata),
        .clear_all (clear_all),
        .rd_hit    (rd_hit),
        .clr_mask  (clr_mask),
        .rd_valid  (rd_valid)
    );

    smr_flag_bank #(.DATA_W(DATA_W), .STICKY(STICKY)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_in (fault_in),
        .clr_mask (clr_mask),
        .stored_q (stored_q),
        .view     (view)
    );

    smr_read_mux #(.DATA_W(DATA_W)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_hit),
        .view    (view),
        .snap_q  (rd_data)
    );

endmodule

// File: rtl/status_mixed_reg_chk.sv
module status_mixed_reg_chk #(
    parameter int unsigned CMD_W        = 8,
    parameter int unsigned DATA_W       = 8,
    parameter logic [CMD_W-1:0] CODE    = 8'h80,
    parameter logic [DATA_W-1:0] STICKY = 8'h7D
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] fault_in,
    input logic              clear_all,
    input logic              cmd_valid,
    input logic              cmd_write,
    input logic [CMD_W-1:0]  cmd_code,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] stored_q
);

    logic rd_req;
    logic wr_req;
    assign rd_req = cmd_valid && !cmd_write && (cmd_code == CODE);
    assign wr_req = cmd_valid &&  cmd_write && (cmd_code == CODE);

    // R9
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R8
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R3
    live_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_data[DATA_W-1] == $past(fault_in[DATA_W-1])));

    // R2
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_in & STICKY) != '0) |=>
            ((stored_q & $past(fault_in & STICKY)) == $past(fault_in & STICKY)));

    // R6
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> ((stored_q & ~$past(fault_in)) == '0));

    // R4
    write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> ((stored_q & $past(cmd_wdata & ~fault_in)) == '0));

endmodule

bind status_mixed_reg status_mixed_reg_chk #(
    .CMD_W(CMD_W), .DATA_W(DATA_W), .CODE(CODE), .STICKY(STICKY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_in  (fault_in),
    .clear_all (clear_all),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_code  (cmd_code),
    .cmd_wdata (cmd_wdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .stored_q  (stored_q)
);

// File: tb/status_mixed_reg_test.sv
module status_mixed_reg_test;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fault_in = '0;
    logic       clear_all = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_code = '0;
    logic [7:0] cmd_wdata = '0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string cur_tag = "R1";

    always #(PERIOD/2) clk = ~clk;

    status_mixed_reg uut (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .clear_all(clear_all),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_code(cmd_code),
        .cmd_wdata(cmd_wdata), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Behavioural reference model
    bit [7:0] m_flags = '0;
    bit       m_valid = 1'b0;
    bit [7:0] m_resp[$];

    always @(posedge clk) begin
        bit [7:0] clr;
        bit [7:0] snap;
        bit       is_rd;
        bit       is_wr;
        if (!rst_n) begin
            m_flags = '0;
            m_valid = 1'b0;
            m_resp.delete();
        end else begin
            is_rd = cmd_valid && !cmd_write && cmd_code == 8'h80;
            is_wr = cmd_valid &&  cmd_write && cmd_code == 8'h80;
            snap  = ((m_flags | fault_in) & 8'h7D) | (fault_in & 8'h82);
            clr   = 8'h00;
            if (is_wr) clr = clr | cmd_wdata;
            if (clear_all) clr = 8'hFF;
            m_flags = ((m_flags & ~clr) | fault_in) & 8'h7D;
            m_valid = is_rd;
            if (is_rd) m_resp.push_back(snap);
        end
    end

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check({cur_tag, " valid"}, {7'd0, rd_valid}, {7'd0, m_valid});
            if (m_valid && m_resp.size() > 0) begin
                check({cur_tag, " data"}, rd_data, m_resp.pop_front());
            end
        end
    end

    // Stimulus helpers: called just after a falling edge, return after the next one
    task automatic idle();
        @(negedge clk);
    endtask

    task automatic do_read_expect(string tag, logic [7:0] exp);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_code = 8'h80;
        @(negedge clk);
        cmd_valid = 1'b0;
        n_checks++;
        if (rd_valid !== 1'b1 || rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b data=%02h expected data=%02h", tag, rd_valid, rd_data, exp);
        end
    endtask

    task automatic do_write(logic [7:0] code, logic [7:0] data);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_code = code; cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_write = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur_tag = "R1";
        check("R1 valid after reset", {7'd0, rd_valid}, 8'h00);
        do_read_expect("R1", 8'h00);

        // R2: one-cycle pulses on sticky positions persist
        cur_tag = "R2";
        fault_in = 8'h41; idle(); fault_in = 8'h00; idle();
        do_read_expect("R2", 8'h41);

        // R3: live positions follow inputs, then drop
        cur_tag = "R3";
        fault_in = 8'h82;
        do_read_expect("R3 high", 8'hC3);
        fault_in = 8'h00;
        do_read_expect("R3 low", 8'h41);

        // R4: per-bit clear
        cur_tag = "R4";
        do_write(8'h80, 8'h40);
        do_read_expect("R4", 8'h01);

        // R5: ones at live positions do nothing
        cur_tag = "R5";
        fault_in = 8'h82;
        do_write(8'h80, 8'h82);
        do_read_expect("R5 still live", 8'h83);
        fault_in = 8'h00;
        do_read_expect("R5 low", 8'h01);

        // R6: global clear
        cur_tag = "R6";
        fault_in = 8'h3C; idle(); fault_in = 8'h00;
        do_read_expect("R6 set", 8'h3D);
        clear_all = 1'b1; idle(); clear_all = 1'b0;
        do_read_expect("R6 cleared", 8'h00);

        // R7: set over clear
        cur_tag = "R7";
        fault_in = 8'h20;
        do_write(8'h80, 8'h20);
        fault_in = 8'h00;
        do_read_expect("R7 write", 8'h20);
        fault_in = 8'h08; clear_all = 1'b1; idle(); clear_all = 1'b0; fault_in = 8'h00;
        do_read_expect("R7 clear_all", 8'h08);

        // R8: other codes ignored
        cur_tag = "R8";
        do_write(8'h81, 8'hFF);
        do_write(8'h00, 8'hFF);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_code = 8'h7F; idle(); cmd_valid = 1'b0;
        check("R8 no response", {7'd0, rd_valid}, 8'h00);
        do_read_expect("R8 unchanged", 8'h08);

        // R9 / R10: back-to-back reads with changing inputs
        cur_tag = "R10";
        clear_all = 1'b1; idle(); clear_all = 1'b0;
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_code = 8'h80;
        fault_in = 8'h80; idle();
        check("R10 first", rd_data, 8'h80);
        fault_in = 8'h02; idle();
        check("R10 second", rd_data, 8'h02);
        cmd_valid = 1'b0; fault_in = 8'h00; idle();
        check("R9 drop", {7'd0, rd_valid}, 8'h00);

        // Mixed pseudo-random traffic against the model
        cur_tag = "R9";
        for (int k = 0; k < 600; k++) begin
            int unsigned r;
            r = $urandom;
            fault_in  = ((r[3:0] == 4'd0) ? 8'(r >> 8) : 8'h00) | (r[4] ? 8'h80 : 8'h00);
            clear_all = (r[7:5] == 3'd0);
            cmd_valid = r[8];
            cmd_write = r[9];
            cmd_code  = (r[11:10] == 2'd0) ? 8'h81 : 8'h80;
            cmd_wdata = 8'(r >> 16);
            idle();
        end
        cmd_valid = 1'b0; clear_all = 1'b0; fault_in = 8'h00;
        idle(); idle();
        finish_run();
    end

endmodule